// File: doc/BRIEF.md
# Selectable-Timebase Event Counter

This block is a shared free-running counter for a bank of timer channels. Its increment is gated by one of six timebase sources, chosen by a 3-bit select field:
- the system clock itself;
- two fixed prescaled copies of the system clock;
- the overflow pulse of a separate general timer;
- the rising edge of an asynchronous external count pin;
- an external oscillator clock divided by eight.

The external oscillator runs in its own clock domain. Its divided output is carried into the system clock domain by toggle synchronisation.

Software reaches two locations through a single write port and a combinational read mux: the count and a control word. The control word holds the source select, a run bit and a sticky wrap flag. The count value, a single-cycle increment strobe and the wrap flag also leave the block as registered outputs, so that capture/compare channels can use them.

Top module: `cta_timebase`

## Requirements
- R1: After synchronous reset, `count_o` is 0, `tick_o` is 0, `ovf_o` is 0, and the control word reads 0 (source code 0, run off).
- R2: A write with `addr`=0 loads `wdata` into the count on that clock edge, so the new value shows on the next cycle. The load takes priority over an increment in the same cycle, produces no tick and never sets the wrap flag.
- R3: A write with `addr`=1 sets the source select from `wdata[2:0]` and the run bit from `wdata[3]`. Reading `addr`=1 returns {ovf flag at bit 4, run at bit 3, select at bits 2:0}, with all higher bits zero. Reading `addr`=0 returns the count.
- R4: While the run bit is 0, the count does not change, except through R2 loads.
- R5: Select code 4 increments the count on every system clock.
- R6: Select code 1 increments once every 4 system clocks, and select code 0 increments once every 12 system clocks. Both prescalers run freely, so any window of 48 clocks yields exactly 12 and 4 increments respectively.
- R7: Select code 2 increments once for each system-clock cycle in which `tmr_ovf` is high.
- R8: Select code 3 increments once for each rising edge of `ext_cnt`, after a two-flop synchroniser. The input must hold each level for at least two system clocks.
- R9: Select code 5 increments once for every 8 rising edges of `osc_clk`.
- R10: Select codes 6 and 7 stop counting even when the run bit is 1.
- R11: An increment from all-ones to zero sets the wrap flag. The flag holds until a control write with `wdata[4]`=0 clears it. A wrap in the same cycle as such a clear leaves the flag set, and writing 1 to bit 4 never sets it.
- R12: `tick_o` is high for exactly those cycles in which `count_o` shows a value one greater than in the previous cycle because of an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, also sampled in the oscillator domain |
| osc_clk | input | 1 | External oscillator clock, asynchronous to `clk` |
| tmr_ovf | input | 1 | Overflow pulse from a general timer, in the `clk` domain |
| ext_cnt | input | 1 | Asynchronous external count input |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 count, 1 control |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| count_o | output | 16 | Current count value |
| tick_o | output | 1 | High in the cycle a freshly incremented count is shown |
| ovf_o | output | 1 | Sticky wrap flag |

## Verification
The properties assume that `tmr_ovf` is already synchronous to `clk`. They also assume that `ext_cnt` holds each level for at least two clocks, and that `osc_clk` is slow enough for its divided toggle to change less often than every two system clocks. The bench keeps within these limits: it changes `ext_cnt` only every four clocks, and it runs `osc_clk` at a 14 ns period against a 10 ns system clock. It also drives `osc_clk` during reset, so the oscillator-domain divider starts from zero. The bench keeps the oscillator stopped outside its own scenario, so the number of divided events it expects is exact.

// File: rtl/cta_pkg.sv
package cta_pkg;
  localparam int SRC_W = 3;
  localparam logic [SRC_W-1:0] SRC_DIVB  = 3'd0;
  localparam logic [SRC_W-1:0] SRC_DIVA  = 3'd1;
  localparam logic [SRC_W-1:0] SRC_TOVF  = 3'd2;
  localparam logic [SRC_W-1:0] SRC_EXTIN = 3'd3;
  localparam logic [SRC_W-1:0] SRC_SYS   = 3'd4;
  localparam logic [SRC_W-1:0] SRC_OSC   = 3'd5;
  localparam logic ADDR_COUNT = 1'b0;
  localparam logic ADDR_CTRL  = 1'b1;
  localparam int CTRL_RUN_BIT = 3;
  localparam int CTRL_OVF_BIT = 4;
endpackage

// File: rtl/cta_sync.sv
module cta_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;
  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end
  assign q = sh[STAGES-1];
endmodule

// File: rtl/cta_prescale.sv
module cta_prescale #(
  parameter int DIV_A = 4,
  parameter int DIV_B = 12
) (
  input  logic clk,
  input  logic rst,
  output logic pulse_a,
  output logic pulse_b
);
  localparam int WA = (DIV_A > 1) ? $clog2(DIV_A) : 1;
  localparam int WB = (DIV_B > 1) ? $clog2(DIV_B) : 1;
  logic [WA-1:0] cnt_a;
  logic [WB-1:0] cnt_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_a   <= '0;
      cnt_b   <= '0;
      pulse_a <= 1'b0;
      pulse_b <= 1'b0;
    end else begin
      cnt_a   <= (cnt_a == WA'(DIV_A - 1)) ? '0 : cnt_a + WA'(1);
      cnt_b   <= (cnt_b == WB'(DIV_B - 1)) ? '0 : cnt_b + WB'(1);
      pulse_a <= (cnt_a == WA'(DIV_A - 1));
      pulse_b <= (cnt_b == WB'(DIV_B - 1));
    end
  end
endmodule

// File: rtl/cta_edge_in.sv
module cta_edge_in #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic s_q, prev_q;
  cta_sync #(.STAGES(STAGES)) u_sync (.clk(clk), .rst(rst), .d(din), .q(s_q));
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= s_q;
  end
  assign rise = s_q & ~prev_q;
endmodule

// File: rtl/cta_osc_div.sv
module cta_osc_div #(
  parameter int DIV    = 8,
  parameter int STAGES = 2
) (
  input  logic osc_clk,
  input  logic clk,
  input  logic rst,
  output logic evt
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] div_q;
  logic         tog_q;
  logic         tog_s, prev_q;

  always_ff @(posedge osc_clk) begin
    if (rst) begin
      div_q <= '0;
      tog_q <= 1'b0;
    end else begin
      div_q <= (div_q == W'(DIV - 1)) ? '0 : div_q + W'(1);
      if (div_q == W'(DIV - 1)) tog_q <= ~tog_q;
    end
  end

  cta_sync #(.STAGES(STAGES)) u_sync (.clk(clk), .rst(rst), .d(tog_q), .q(tog_s));

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= tog_s;
  end
  assign evt = tog_s ^ prev_q;
endmodule

// File: rtl/cta_timebase.sv
module cta_timebase
  import cta_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_A       = 4,
  parameter int PRE_B       = 12,
  parameter int OSC_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_clk,
  input  logic             tmr_ovf,
  input  logic             ext_cnt,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic [CNT_W-1:0] count_o,
  output logic             tick_o,
  output logic             ovf_o
);
  localparam int CTRL_W = CTRL_OVF_BIT + 1;

  logic [SRC_W-1:0] src_q;
  logic             run_q;
  logic             pre_a, pre_b, ext_rise, osc_evt;
  logic             sel_evt, inc, wr_cnt, wr_ctl;

  cta_prescale #(.DIV_A(PRE_A), .DIV_B(PRE_B)) u_pre (
    .clk(clk), .rst(rst), .pulse_a(pre_a), .pulse_b(pre_b)
  );
  cta_edge_in #(.STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst(rst), .din(ext_cnt), .rise(ext_rise)
  );
  cta_osc_div #(.DIV(OSC_DIV), .STAGES(SYNC_STAGES)) u_osc (
    .osc_clk(osc_clk), .clk(clk), .rst(rst), .evt(osc_evt)
  );

  always_comb begin
    case (src_q)
      SRC_DIVB:  sel_evt = pre_b;
      SRC_DIVA:  sel_evt = pre_a;
      SRC_TOVF:  sel_evt = tmr_ovf;
      SRC_EXTIN: sel_evt = ext_rise;
      SRC_SYS:   sel_evt = 1'b1;
      SRC_OSC:   sel_evt = osc_evt;
      default:   sel_evt = 1'b0;
    endcase
  end

  assign wr_cnt = wr_en && (addr == ADDR_COUNT);
  assign wr_ctl = wr_en && (addr == ADDR_CTRL);
  assign inc    = run_q && sel_evt && !wr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      tick_o  <= 1'b0;
      ovf_o   <= 1'b0;
      run_q   <= 1'b0;
      src_q   <= '0;
    end else begin
      if (wr_cnt)   count_o <= wdata;
      else if (inc) count_o <= count_o + CNT_W'(1);
      tick_o <= inc;
      if (wr_ctl) begin
        src_q <= wdata[SRC_W-1:0];
        run_q <= wdata[CTRL_RUN_BIT];
      end
      if (inc && (count_o == {CNT_W{1'b1}}))      ovf_o <= 1'b1;
      else if (wr_ctl && !wdata[CTRL_OVF_BIT])    ovf_o <= 1'b0;
    end
  end

  always_comb begin
    if (addr == ADDR_CTRL)
      rdata = {{(CNT_W-CTRL_W){1'b0}}, ovf_o, run_q, src_q};
    else
      rdata = count_o;
  end
endmodule

// File: rtl/cta_timebase_chk.sv
module cta_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             addr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] count_o,
  input logic             tick_o,
  input logic             ovf_o,
  input logic             run_q,
  input logic [2:0]       src_q
);
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr) |=> (count_o == $past(wdata)) && !tick_o);

  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !(wr_en && !addr)) |=> $stable(count_o));

  p_sys_r5: assert property (@(posedge clk) disable iff (rst)
    (run_q && src_q == 3'd4 && !(wr_en && !addr)) |=> tick_o);

  p_stop_r10: assert property (@(posedge clk) disable iff (rst)
    (run_q && src_q[2:1] == 2'b11 && !(wr_en && !addr)) |=> $stable(count_o));

  p_wrap_r11: assert property (@(posedge clk) disable iff (rst)
    (tick_o && count_o == '0) |-> ovf_o);

  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !(wr_en && addr && !wdata[4])) |=> ovf_o);

  p_tick_r12: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (count_o == $past(count_o) + CNT_W'(1)));
endmodule

bind cta_timebase cta_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .count_o(count_o), .tick_o(tick_o), .ovf_o(ovf_o),
  .run_q(run_q), .src_q(src_q)
);

// File: tb/sim_cta_timebase.sv
module sim_cta_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int OSC_HALF   = 7;

  logic        clk = 1'b0, rst = 1'b1, osc_clk = 1'b0;
  logic        tmr_ovf = 1'b0, ext_cnt = 1'b0, wr_en = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, count_o;
  logic        tick_o, ovf_o;
  int          n_chk = 0, n_err = 0;

  cta_timebase u0 (
    .clk(clk), .rst(rst), .osc_clk(osc_clk), .tmr_ovf(tmr_ovf),
    .ext_cnt(ext_cnt), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .count_o(count_o), .tick_o(tick_o), .ovf_o(ovf_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge; returns at next negedge
  task automatic wr(input logic a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    addr = a; #1; d = rdata; addr = 1'b0;
  endtask

  // run a source for exactly n sampling edges starting from count 0
  task automatic window(input logic [2:0] src, input int n, output logic [15:0] res);
    wr(1'b0, 16'h0000);
    wr(1'b1, {12'h0, 1'b1, src});
    repeat (n-1) @(negedge clk);
    wr(1'b1, {13'h0, src});
    rd(1'b0, res);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 count", count_o, 0);
    check("R1 tick", tick_o, 0);
    check("R1 ovf", ovf_o, 0);
    rd(1'b1, v);
    check("R1 ctrl", v, 0);
  endtask

  task automatic t_ctrl;
    logic [15:0] v;
    wr(1'b1, 16'h0015);
    rd(1'b1, v);
    check("R3 ctrl readback, bit4 write ignored", v, 16'h0005);
    wr(1'b0, 16'h00A5);
    rd(1'b0, v);
    check("R3 count readback", v, 16'h00A5);
    wr(1'b1, 16'h0004);
  endtask

  task automatic t_sys;
    logic [15:0] v;
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h000C);
    check("R12 no tick before first edge", tick_o, 0);
    @(negedge clk);
    check("R5 first increment", count_o, 1);
    check("R12 tick with increment", tick_o, 1);
    wr(1'b1, 16'h0004);
    window(3'd4, 48, v);
    check("R5 sysclk window", v, 48);
  endtask

  task automatic t_pre;
    logic [15:0] v;
    window(3'd1, 48, v);
    check("R6 div4 window", v, 12);
    window(3'd0, 48, v);
    check("R6 div12 window", v, 4);
  endtask

  task automatic t_run_off;
    wr(1'b0, 16'h0077);
    wr(1'b1, 16'h0004);
    repeat (20) @(negedge clk);
    check("R4 run off holds", count_o, 16'h0077);
  endtask

  task automatic t_stop;
    wr(1'b0, 16'h0040);
    wr(1'b1, 16'h000E);
    repeat (20) @(negedge clk);
    check("R10 code 6 stops", count_o, 16'h0040);
    wr(1'b1, 16'h000F);
    repeat (20) @(negedge clk);
    check("R10 code 7 stops", count_o, 16'h0040);
    wr(1'b1, 16'h0007);
  endtask

  task automatic t_tovf;
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h000A);
    for (int i = 0; i < 3; i++) begin
      tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
      repeat (3) @(negedge clk);
    end
    tmr_ovf = 1'b1; repeat (2) @(negedge clk); tmr_ovf = 1'b0;
    repeat (3) @(negedge clk);
    wr(1'b1, 16'h0002);
    check("R7 timer overflow pulses", count_o, 5);
  endtask

  task automatic t_ext;
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h000B);
    for (int i = 0; i < 6; i++) begin
      ext_cnt = 1'b1; repeat (4) @(negedge clk);
      ext_cnt = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    wr(1'b1, 16'h0003);
    check("R8 external edges", count_o, 6);
  endtask

  task automatic t_osc;
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h000D);
    for (int i = 0; i < 48; i++) begin
      #(OSC_HALF); osc_clk = ~osc_clk;
    end
    repeat (20) @(negedge clk);
    wr(1'b1, 16'h0005);
    check("R9 oscillator div8", count_o, 3);
  endtask

  task automatic t_load;
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h000C);
    wr(1'b0, 16'h1234);
    check("R2 load wins", count_o, 16'h1234);
    check("R2 no tick on load", tick_o, 0);
    @(negedge clk);
    check("R2 counts on after load", count_o, 16'h1235);
    wr(1'b1, 16'h0004);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    wr(1'b0, 16'hFFFF);
    check("R2 load to all-ones sets no flag", ovf_o, 0);
    wr(1'b0, 16'hFFFE);
    wr(1'b1, 16'h000C);
    @(negedge clk);
    check("R11 at all-ones", count_o, 16'hFFFF);
    wr(1'b1, 16'h000C);
    check("R11 wrap to zero", count_o, 0);
    check("R11 wrap beats clear", ovf_o, 1);
    wr(1'b1, 16'h0014);
    repeat (5) @(negedge clk);
    check("R11 flag sticky", ovf_o, 1);
    rd(1'b1, v);
    check("R3 ovf bit readback", v, 16'h0014);
    wr(1'b1, 16'h0004);
    check("R11 flag cleared", ovf_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      #(OSC_HALF); osc_clk = ~osc_clk;
    end
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_sys();
    t_pre();
    t_run_off();
    t_stop();
    t_tovf();
    t_ext();
    t_osc();
    t_load();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule